// File: doc/BRIEF.md
# Serial Control Transaction Decoder

This block is the receiving half of a chip's slow-control port on a shared, half-duplex serial line that runs on the system clock. On every rising clock edge it samples the line. It assembles 10-bit characters from the samples and follows each control transaction from its first character, the operation code, to its end.

The block turns that traffic into single-cycle events for the rest of the chip:
- a trigger pulse, raised before the trigger character has fully arrived;
- one strobe bit per broadcast command;
- a register write strobe, with a 16-bit address and 16-bit data;
- a read request, with a 16-bit address.

Writes are filtered against a 7-bit identifier strapped on an input. The filter accepts the chip's own code, a global code, and a code shared by all chips in one row of one outer module. Reads are honoured only for the chip's own code.

The reply driver, the register file and the line drivers sit outside this block.

Top module: `ctrl_rx_decoder`

## Requirements
- R1: A character is a 0 start bit, then eight payload bits with the least significant bit first, then a stop bit of 1. The idle line is 1, and a 0 sampled while idle begins a character.
- R2: Characters that follow each other with no idle cycle between them (the next start bit sampled on the edge after a stop bit) are all decoded.
- R3: `trigOut` is high for exactly one cycle when both of these hold: the decoder is waiting for an operation code, and the first two payload bits of a character are D0=1 and D1=0. The pulse appears in the cycle after the edge that samples D1, which is before that character's stop bit. Trigger codes are 0xB1, 0x55, 0xC9 and 0x2D. A character later in a transaction never raises it.
- R4: Each broadcast code raises one `cmdStb` bit for one cycle, one edge after the edge that samples its stop bit. The mapping is: 0xD2 to bit 0, 0xE4 to bit 1, 0x78 to bit 2, 0x36 to bit 3, 0xAA to bit 4, 0x63 to bit 5.
- R5: A write is six characters: 0x9C, identifier, address low byte, address high byte, data low byte, data high byte. If it is accepted, `wrStb` is high for one cycle, one edge after the last stop bit. In that cycle `regAddr` = {high, low} and `wrData` = {high, low}.
- R6: With strapped identifier `id`, a write is accepted for any of these identifier bytes:
  - 0x0F;
  - {0, id};
  - {0, id[6:3], 3'b111}, but only when id[6:4] is not 000 (an outer chip).
  An inner chip does not accept the row code. `chipId` changes only while in reset.
- R7: A read is four characters: 0x4E, identifier, address low byte, address high byte. `rdReq` is high for one cycle, one edge after the last stop bit, with `regAddr` = {high, low}. This happens only when the identifier byte equals {0, id}. It never happens for 0x0F or a row code.
- R8: Up to 42 idle cycles between the characters of a transaction keep it alive. A 43rd idle cycle aborts the transaction with no strobe, and the next character is taken as an operation code.
- R9: A stop bit sampled as 0 drops the current transaction. The line is then ignored until a 1 has been sampled, and the next 0 after that starts a new character.
- R10: While reset is asserted, `trigOut`, `cmdStb`, `wrStb` and `rdReq` are all 0.
- R11: A first character that is not a defined code starts no transaction and raises no strobe. Such a character does not also have D0=1 and D1=0.
- R12: In any cycle, at most one of these is active: trigger, a command, write, read. At most one `cmdStb` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the line is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Serial control line, idle high |
| chipId | input | 7 | Strapped chip identifier ([6:4] module, [3] row, [2:0] position) |
| trigOut | output | 1 | Early trigger pulse |
| cmdStb | output | 6 | One-cycle broadcast command strobes |
| wrStb | output | 1 | One-cycle register write strobe |
| rdReq | output | 1 | One-cycle read request for this chip |
| regAddr | output | 16 | Register address of the latest write or read |
| wrData | output | 16 | Data of the latest write |

## Verification
The checks assume that `chipId` stays fixed outside reset, and one assertion states this. The bench changes the identifier only inside its reset task.

The exclusivity check across trigger, command, write and read relies on the line carrying no first character that has D0=1 and D1=0 yet is not a trigger code. The bench keeps every stray or orphaned character it sends (after an abort or a framing error) to payloads whose two low bits are 00 or 10. It also always returns the line to 1 after a bad stop bit before it starts the next character.

// File: rtl/ctrlrx_pkg.sv
package ctrlrx_pkg;

  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 16;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int ID_W       = 7;
  localparam int ID_ROW_BIT = 3;
  localparam int ID_POS_W   = 3;
  localparam int NUM_CMDS   = 6;

  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h9C;
  localparam logic [BYTE_W-1:0] OP_READ   = 8'h4E;
  localparam logic [BYTE_W-1:0] ID_GLOBAL = 8'h0F;
  localparam logic [1:0]        TRIG_LSBS = 2'b01;   // {D1, D0} of every trigger code

  // Index in this table is the cmdStb bit raised for that code.
  localparam logic [BYTE_W-1:0] CMD_CODES [NUM_CMDS] =
    '{8'hD2, 8'hE4, 8'h78, 8'h36, 8'hAA, 8'h63};

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_HUNT} rxState_t;

  typedef enum logic [2:0] {
    ST_OPCODE, ST_CHIPID, ST_ADDRLO, ST_ADDRHI, ST_DATALO, ST_DATAHI
  } txnState_t;

  // Control -> datapath: which word byte to capture this cycle.
  typedef struct packed {
    logic [WORD_BYTES-1:0] capAddr;
    logic [WORD_BYTES-1:0] capData;
  } dpCtl_t;

  // Datapath -> control: character events and identifier match.
  typedef struct packed {
    logic              charValid;
    logic [BYTE_W-1:0] charByte;
    logic              frameErr;
    logic              gapTimeout;
    logic              earlyTrig;
    logic              idOwn;
    logic              idGroup;
  } dpStat_t;

endpackage

// File: rtl/ctrlrx_datapath.sv
module ctrlrx_datapath
  import ctrlrx_pkg::*;
#(
  parameter int MAX_GAP = 42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic [ID_W-1:0]   chipId,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  output logic [WORD_W-1:0] regAddr,
  output logic [WORD_W-1:0] wrData
);

  localparam int BIT_W = $clog2(BYTE_W + 2);
  localparam int GAP_W = $clog2(MAX_GAP + 2);
  localparam logic [BIT_W-1:0] STOP_POS = BIT_W'(BYTE_W + 1);
  localparam logic [BIT_W-1:0] D1_POS   = BIT_W'(2);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(MAX_GAP);
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(MAX_GAP + 1);
  localparam int MOD_LSB = ID_ROW_BIT + 1;

  rxState_t          rxState;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] charByte;
  logic              charValid, frameErr, earlyTrig, gapTimeout;
  logic [GAP_W-1:0]  gapCnt;
  logic              outerRole, idOwn, idGroup;

  // Deserializer: start detect, LSB-first shift, stop check, early trigger.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState   <= RX_IDLE;
      bitCnt    <= '0;
      shReg     <= '0;
      charByte  <= '0;
      charValid <= 1'b0;
      frameErr  <= 1'b0;
      earlyTrig <= 1'b0;
    end else begin
      charValid <= 1'b0;
      frameErr  <= 1'b0;
      earlyTrig <= 1'b0;
      unique case (rxState)
        RX_IDLE: begin
          if (!lineIn) begin
            rxState <= RX_BITS;
            bitCnt  <= BIT_W'(1);
          end
        end
        RX_BITS: begin
          if (bitCnt == STOP_POS) begin
            bitCnt <= '0;
            if (lineIn) begin
              charValid <= 1'b1;
              charByte  <= shReg;
              rxState   <= RX_IDLE;
            end else begin
              frameErr <= 1'b1;
              rxState  <= RX_HUNT;
            end
          end else begin
            shReg  <= {lineIn, shReg[BYTE_W-1:1]};
            bitCnt <= bitCnt + BIT_W'(1);
            if (bitCnt == D1_POS && {lineIn, shReg[BYTE_W-1]} == TRIG_LSBS)
              earlyTrig <= 1'b1;
          end
        end
        RX_HUNT: begin
          if (lineIn) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // Idle-gap counter: counts idle samples between characters, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt     <= '0;
      gapTimeout <= 1'b0;
    end else begin
      gapTimeout <= 1'b0;
      if (rxState == RX_IDLE && lineIn) begin
        if (gapCnt == GAP_LAST) begin
          gapTimeout <= 1'b1;
          gapCnt     <= GAP_SAT;
        end else if (gapCnt != GAP_SAT) begin
          gapCnt <= gapCnt + GAP_W'(1);
        end
      end else begin
        gapCnt <= '0;
      end
    end
  end

  // Word assembly for address and data, one byte per capture strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr <= '0;
      wrData  <= '0;
    end else begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (ctl.capAddr[b]) regAddr[b*BYTE_W +: BYTE_W] <= charByte;
        if (ctl.capData[b]) wrData[b*BYTE_W +: BYTE_W]  <= charByte;
      end
    end
  end

  // Identifier match against the strapped chip code.
  assign outerRole = |chipId[ID_W-1:MOD_LSB];
  assign idOwn     = (charByte == {1'b0, chipId});
  assign idGroup   = (charByte == ID_GLOBAL) ||
                     (outerRole &&
                      charByte == {1'b0, chipId[ID_W-1:ID_ROW_BIT], {ID_POS_W{1'b1}}});

  assign stat.charValid  = charValid;
  assign stat.charByte   = charByte;
  assign stat.frameErr   = frameErr;
  assign stat.gapTimeout = gapTimeout;
  assign stat.earlyTrig  = earlyTrig;
  assign stat.idOwn      = idOwn;
  assign stat.idGroup    = idGroup;

endmodule

// File: rtl/ctrlrx_control.sv
module ctrlrx_control
  import ctrlrx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStat_t             stat,
  output dpCtl_t              ctl,
  output logic                trigOut,
  output logic [NUM_CMDS-1:0] cmdStb,
  output logic                wrStb,
  output logic                rdReq
);

  txnState_t           state;
  logic                isRead, hitOwn, hitAny;
  logic [NUM_CMDS-1:0] cmdHit;

  for (genvar g = 0; g < NUM_CMDS; g++) begin : gCmd
    assign cmdHit[g] = (stat.charByte == CMD_CODES[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OPCODE;
      isRead <= 1'b0;
      hitOwn <= 1'b0;
      hitAny <= 1'b0;
      cmdStb <= '0;
      wrStb  <= 1'b0;
      rdReq  <= 1'b0;
    end else begin
      cmdStb <= '0;
      wrStb  <= 1'b0;
      rdReq  <= 1'b0;
      if (stat.frameErr || stat.gapTimeout) begin
        state <= ST_OPCODE;
      end else if (stat.charValid) begin
        unique case (state)
          ST_OPCODE: begin
            if (stat.charByte == OP_WRITE) begin
              isRead <= 1'b0;
              state  <= ST_CHIPID;
            end else if (stat.charByte == OP_READ) begin
              isRead <= 1'b1;
              state  <= ST_CHIPID;
            end else begin
              cmdStb <= cmdHit;
            end
          end
          ST_CHIPID: begin
            hitOwn <= stat.idOwn;
            hitAny <= stat.idOwn || stat.idGroup;
            state  <= ST_ADDRLO;
          end
          ST_ADDRLO: state <= ST_ADDRHI;
          ST_ADDRHI: begin
            if (isRead) begin
              rdReq <= hitOwn;
              state <= ST_OPCODE;
            end else begin
              state <= ST_DATALO;
            end
          end
          ST_DATALO: state <= ST_DATAHI;
          ST_DATAHI: begin
            wrStb <= hitAny;
            state <= ST_OPCODE;
          end
          default: state <= ST_OPCODE;
        endcase
      end
    end
  end

  assign trigOut     = stat.earlyTrig && (state == ST_OPCODE);
  assign ctl.capAddr = {stat.charValid && state == ST_ADDRHI,
                        stat.charValid && state == ST_ADDRLO};
  assign ctl.capData = {stat.charValid && state == ST_DATAHI,
                        stat.charValid && state == ST_DATALO};

endmodule

// File: rtl/ctrl_rx_decoder.sv
module ctrl_rx_decoder
  import ctrlrx_pkg::*;
#(
  parameter int MAX_GAP = 42
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineIn,
  input  logic [ID_W-1:0]     chipId,
  output logic                trigOut,
  output logic [NUM_CMDS-1:0] cmdStb,
  output logic                wrStb,
  output logic                rdReq,
  output logic [WORD_W-1:0]   regAddr,
  output logic [WORD_W-1:0]   wrData
);

  dpCtl_t  ctl;
  dpStat_t stat;

  ctrlrx_datapath #(.MAX_GAP(MAX_GAP)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (lineIn),
    .chipId  (chipId),
    .ctl     (ctl),
    .stat    (stat),
    .regAddr (regAddr),
    .wrData  (wrData)
  );

  ctrlrx_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .ctl     (ctl),
    .trigOut (trigOut),
    .cmdStb  (cmdStb),
    .wrStb   (wrStb),
    .rdReq   (rdReq)
  );

endmodule

// File: rtl/ctrlrx_checker.sv
module ctrlrx_checker
  import ctrlrx_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [ID_W-1:0]     chipId,
  input logic                trigOut,
  input logic [NUM_CMDS-1:0] cmdStb,
  input logic                wrStb,
  input logic                rdReq
);

  a_r12_cmd_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStb));

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trigOut, |cmdStb, wrStb, rdReq}));

  a_r3_trig_single: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  a_r4_cmd_single: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb != '0) |=> (cmdStb == '0));

  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  a_r7_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R6: the strapped identifier is held constant outside reset.
  a_r6_id_static: assert property (@(posedge clk) disable iff (!rstN)
    $stable(chipId));

endmodule

bind ctrl_rx_decoder ctrlrx_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .chipId  (chipId),
  .trigOut (trigOut),
  .cmdStb  (cmdStb),
  .wrStb   (wrStb),
  .rdReq   (rdReq)
);

// File: tb/tb_ctrl_rx_decoder.sv
`timescale 1ns/1ps
module tb_ctrl_rx_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineIn = 1'b1;
  logic [6:0]  chipId = 7'h00;
  logic        trigOut, wrStb, rdReq;
  logic [5:0]  cmdStb;
  logic [15:0] regAddr, wrData;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    chkOn = 1'b0;
  string curReq = "R10";
  logic [6:0] myId = 7'h00;

  // Expected events keyed by the cycle number at which they are observed.
  bit          expTrig [int];
  logic [5:0]  expCmd  [int];
  logic [31:0] expWr   [int];
  logic [15:0] expRd   [int];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctrl_rx_decoder dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .chipId(chipId),
    .trigOut(trigOut), .cmdStb(cmdStb), .wrStb(wrStb), .rdReq(rdReq),
    .regAddr(regAddr), .wrData(wrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the expectation tables.
  always @(negedge clk) begin
    bit          eT;
    logic [5:0]  eC;
    bit          eW, eR;
    if (chkOn) begin
      eT = expTrig.exists(cyc);
      eC = expCmd.exists(cyc) ? expCmd[cyc] : 6'd0;
      eW = expWr.exists(cyc);
      eR = expRd.exists(cyc);
      check(trigOut === eT, {curReq, " R3"}, "trigOut", longint'(trigOut), longint'(eT));
      check(cmdStb === eC, {curReq, " R4"}, "cmdStb", longint'(cmdStb), longint'(eC));
      check(wrStb === eW, {curReq, " R5"}, "wrStb", longint'(wrStb), longint'(eW));
      if (eW)
        check({regAddr, wrData} === expWr[cyc], {curReq, " R5"}, "addr/data",
              longint'({regAddr, wrData}), longint'(expWr[cyc]));
      check(rdReq === eR, {curReq, " R7"}, "rdReq", longint'(rdReq), longint'(eR));
      if (eR)
        check(regAddr === expRd[cyc], {curReq, " R7"}, "read addr",
              longint'(regAddr), longint'(expRd[cyc]));
      check($onehot0({trigOut, |cmdStb, wrStb, rdReq}) && $onehot0(cmdStb), "R12",
            "strobe overlap", longint'({trigOut, cmdStb, wrStb, rdReq}), 0);
    end
  end

  always @(posedge clk) begin
    if (cyc == 60000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 60000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Behavioural model of the requirements.
  function automatic logic [5:0] cmdOf(input logic [7:0] b);
    case (b)
      8'hD2: return 6'b000001;
      8'hE4: return 6'b000010;
      8'h78: return 6'b000100;
      8'h36: return 6'b001000;
      8'hAA: return 6'b010000;
      8'h63: return 6'b100000;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic bit isTrig(input logic [7:0] b);
    return (b == 8'hB1) || (b == 8'h55) || (b == 8'hC9) || (b == 8'h2D);
  endfunction

  function automatic bit wrAccept(input logic [7:0] b);
    bit rowCode;
    rowCode = (myId[6:4] != 3'b000) && (b[7] == 1'b0) &&
              (b[6:3] == myId[6:3]) && (b[2:0] == 3'b111);
    return (b == 8'h0F) || (b == {1'b0, myId}) || rowCode;
  endfunction

  task automatic sendBit(input bit b, output int edgeNo);
    @(negedge clk);
    lineIn = b;
    edgeNo = cyc + 1;
  endtask

  task automatic idle(input int n);
    int e;
    for (int i = 0; i < n; i++) sendBit(1'b1, e);
  endtask

  task automatic sendChar(input logic [7:0] v, input bit stopVal, input bit trigExp,
                          output int stopEdge);
    int e;
    sendBit(1'b0, e);
    for (int i = 0; i < 8; i++) begin
      sendBit(v[i], e);
      if (i == 1 && trigExp) expTrig[e] = 1'b1;
    end
    sendBit(stopVal, e);
    stopEdge = e;
  endtask

  task automatic sendOp(input logic [7:0] v, input int gap);
    int s;
    sendChar(v, 1'b1, isTrig(v), s);
    if (cmdOf(v) != 6'd0) expCmd[s + 1] = cmdOf(v);
    idle(gap);
  endtask

  task automatic sendWrite(input logic [7:0] idB, input logic [15:0] addr,
                           input logic [15:0] data, input int gap);
    int s;
    logic [7:0] seq [6];
    seq = '{8'h9C, idB, addr[7:0], addr[15:8], data[7:0], data[15:8]};
    for (int i = 0; i < 6; i++) begin
      sendChar(seq[i], 1'b1, 1'b0, s);
      if (i == 5 && wrAccept(idB)) expWr[s + 1] = {addr, data};
      idle(gap);
    end
  endtask

  task automatic sendRead(input logic [7:0] idB, input logic [15:0] addr, input int gap);
    int s;
    logic [7:0] seq [4];
    seq = '{8'h4E, idB, addr[7:0], addr[15:8]};
    for (int i = 0; i < 4; i++) begin
      sendChar(seq[i], 1'b1, 1'b0, s);
      if (i == 3 && idB == {1'b0, myId}) expRd[s + 1] = addr;
      idle(gap);
    end
  endtask

  task automatic doReset(input logic [6:0] id);
    chkOn  = 1'b0;
    @(negedge clk);
    rstN   = 1'b0;
    lineIn = 1'b1;
    chipId = id;
    myId   = id;
    repeat (3) @(negedge clk);
    curReq = "R10";
    check(trigOut === 1'b0 && cmdStb === 6'd0 && wrStb === 1'b0 && rdReq === 1'b0,
          "R10", "outputs in reset", longint'({trigOut, cmdStb, wrStb, rdReq}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkOn = 1'b1;
  endtask

  initial begin
    int s;
    doReset(7'h1A);   // outer module 1, row 1, slave position 2

    curReq = "R1 R4";
    sendOp(8'hD2, 3); sendOp(8'hE4, 3); sendOp(8'h78, 3);
    sendOp(8'h36, 3); sendOp(8'hAA, 3); sendOp(8'h63, 3);

    curReq = "R11";
    sendOp(8'h12, 3); sendOp(8'h00, 3); sendOp(8'hFE, 3);
    sendOp(8'h63, 3);

    curReq = "R3";
    sendOp(8'hB1, 2); sendOp(8'h55, 2); sendOp(8'hC9, 2); sendOp(8'h2D, 2);
    sendWrite(8'h1A, 16'hB155, 16'h2DC9, 2);   // trigger codes as payload: no trigger

    curReq = "R5 R6";
    sendWrite(8'h1A, 16'h1234, 16'hBEEF, 1);   // own code
    sendWrite(8'h0F, 16'h0102, 16'h0304, 1);   // global
    sendWrite(8'h1F, 16'hA0A1, 16'hB0B1, 1);   // own module and row
    sendWrite(8'h17, 16'hC0C1, 16'hD0D1, 1);   // other row: rejected
    sendWrite(8'h2F, 16'hC2C3, 16'hD2D3, 1);   // other module: rejected
    sendWrite(8'h1B, 16'hC4C5, 16'hD4D5, 1);   // other chip: rejected

    curReq = "R7";
    sendRead(8'h1A, 16'h4321, 1);
    sendRead(8'h0F, 16'h1111, 1);
    sendRead(8'h1F, 16'h2222, 1);
    sendRead(8'h1C, 16'h3333, 1);

    curReq = "R2";
    sendOp(8'hE4, 0); sendOp(8'h55, 0); sendOp(8'h36, 0);
    sendWrite(8'h1A, 16'h5A5A, 16'hA5A5, 0);
    sendRead(8'h1A, 16'h0F0F, 0);
    idle(4);

    curReq = "R8";
    sendWrite(8'h1A, 16'h7788, 16'h99AA, 42);  // longest legal gap
    sendChar(8'h9C, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h1A, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h77, 1'b1, 1'b0, s); idle(43);  // one idle cycle too many
    sendChar(8'h20, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h34, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h12, 1'b1, 1'b0, s); idle(6);
    sendOp(8'h78, 3);

    curReq = "R9";
    sendChar(8'h9C, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h1A, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h66, 1'b0, 1'b0, s);            // bad stop bit
    for (int i = 0; i < 3; i++) sendBit(1'b0, s);
    idle(2);
    sendChar(8'h20, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h34, 1'b1, 1'b0, s); idle(1);
    sendChar(8'h12, 1'b1, 1'b0, s); idle(2);
    sendOp(8'hD2, 3);

    doReset(7'h05);   // inner chip, position 5
    curReq = "R6";
    sendWrite(8'h05, 16'h0505, 16'h5050, 1);
    sendWrite(8'h0F, 16'h0F0F, 16'hF0F0, 1);
    sendWrite(8'h07, 16'h0707, 16'h7070, 1);   // row code: not for inner chips
    sendWrite(8'h0D, 16'h0D0D, 16'hD0D0, 1);
    curReq = "R7";
    sendRead(8'h05, 16'hCAFE, 1);
    sendRead(8'h07, 16'hFACE, 1);

    doReset(7'h28);   // outer module 2, row 1, master
    curReq = "R6";
    sendWrite(8'h2F, 16'h2F2F, 16'h1357, 1);
    sendWrite(8'h27, 16'h2727, 16'h2468, 1);   // other row: rejected
    sendWrite(8'h28, 16'h2828, 16'h8282, 1);
    curReq = "R3";
    sendOp(8'hC9, 2);

    idle(10);
    chkOn = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule